// File: doc/BRIEF.md
# Serial DAC Front-End Controller

This block is the digital front end of a 16-bit segmented voltage-output converter. A host writes it over a three-wire serial link made of an active-low frame select, a serial clock and a data line. All three lines are sampled by a faster system clock through synchronizers, and edges are detected in that clock domain. Each frame carries a 24-bit word, most significant bit first. The word is captured on falling serial-clock edges and takes effect on the 24th falling edge. It does not wait for frame select to rise.

A completed word loads a 16-bit converter code register and a 2-bit power-down mode register. From the code register the block drives two sets of switch controls. The upper four code bits become a 15-line thermometer code for the matched-segment section. The lower twelve bits drive the binary ladder switches directly. In any power-down mode every switch control is held low, and the mode output tells the analog side which output termination to apply. At reset the code register takes midscale or zero-scale, as a parameter selects, and the mode is normal.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, and after each completed frame, no word is accepted until frame select has been sampled high at least once and then sampled low.
- R2: While a frame is open, each falling serial-clock edge shifts the data line into the word, most significant bit first (word bit 23 arrives first).
- R3: On the 24th falling edge the word takes effect with frame select still low. The outputs change at the third rising system-clock edge after that serial-clock fall reaches the input, and never at any other time.
- R4: Word bits 15:0 are loaded into `dac_code_o` when the word takes effect.
- R5: Word bits 17:16 are loaded into `pd_mode_o`: 00 = normal, 01 = output high impedance, 10 = 100 kOhm to ground, 11 = 1 kOhm to ground.
- R6: Word bits 23:18 have no effect on any output.
- R7: In normal mode, `therm_o[i]` is 1 exactly when `dac_code_o[15:12]` is greater than i, for i = 0 to 14.
- R8: In normal mode, `ladder_o` equals `dac_code_o[11:0]`.
- R9: At reset `dac_code_o` is 16'h8000 when MIDSCALE_RST is 1 (the default) and 0 otherwise, and `pd_mode_o` is 00.
- R10: If frame select rises before the 24th bit, the partial word is dropped and no output changes.
- R11: Falling serial-clock edges after the 24th bit, while frame select stays low, change nothing.
- R12: In any mode other than 00, `therm_o` and `ladder_o` are all zero, and `dac_code_o` keeps the loaded code.
- R13: A single system-clock cycle with frame select high is enough to re-arm the block for the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_ni | input | 1 | Frame select, active low |
| sck_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| dac_code_o | output | 16 | Converter code register |
| pd_mode_o | output | 2 | Power-down mode code |
| therm_o | output | 15 | Thermometer controls for the segment switches |
| ladder_o | output | 12 | Binary ladder switch controls |

## Verification
The assertions assume that each serial line stays at one level for at least two system-clock cycles. This lets every level and edge pass through the synchronizers. They also assume that the serial clock does not fall in the same sampled cycle in which frame select falls. The stimulus meets both assumptions. It holds every serial-clock phase for four system cycles. It moves data three cycles before the falling edge. It leaves several idle cycles between the fall of frame select and the first serial-clock fall. Re-arming uses a high pulse on frame select of exactly one cycle, the shortest the block must accept.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_HIZ    = 2'b01,
    PD_R100K  = 2'b10,
    PD_R1K    = 2'b11
  } pd_mode_e;

  typedef enum logic [1:0] {
    FR_WAIT,
    FR_ARMED,
    FR_SHIFT
  } fr_state_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fs_n_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               exec_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  fr_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic             sck_q;
  logic             fall;

  assign fall   = sck_q & ~sck_i;
  assign word_o = {sr_q[FRAME_W-2:0], sdi_i};
  assign exec_o = (state_q == FR_SHIFT) && !fs_n_i && fall && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_WAIT;
      cnt_q   <= '0;
      sr_q    <= '0;
      sck_q   <= 1'b0;
    end else begin
      sck_q <= sck_i;
      unique case (state_q)
        FR_WAIT:  if (fs_n_i) state_q <= FR_ARMED;
        FR_ARMED: if (!fs_n_i) begin
          state_q <= FR_SHIFT;
          cnt_q   <= '0;
        end
        FR_SHIFT: begin
          if (fs_n_i) begin
            // early rise: drop partial word
            state_q <= FR_ARMED;
            cnt_q   <= '0;
          end else if (fall) begin
            sr_q <= word_o;
            if (cnt_q == LAST) begin
              state_q <= FR_WAIT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= FR_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int FRAME_W     = 24,
  parameter int DATA_W      = 16,
  parameter bit MIDSCALE_RST = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [DATA_W-1:0]  code_o,
  output pd_mode_e           mode_o
);
  localparam logic [DATA_W-1:0] RST_CODE =
    MIDSCALE_RST ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= RST_CODE;
      mode_o <= PD_NORMAL;
    end else if (exec_i) begin
      code_o <= word_i[DATA_W-1:0];
      mode_o <= pd_mode_e'(word_i[DATA_W+1:DATA_W]);
    end
  end
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode #(
  parameter int SEG_W    = 4,
  parameter int LADDER_W = 12,
  localparam int THERM_W = (1 << SEG_W) - 1
) (
  input  logic                en_i,
  input  logic [SEG_W-1:0]    seg_i,
  input  logic [LADDER_W-1:0] bin_i,
  output logic [THERM_W-1:0]  therm_o,
  output logic [LADDER_W-1:0] ladder_o
);
  for (genvar i = 0; i < THERM_W; i++) begin : g_therm
    assign therm_o[i] = en_i && (int'(seg_i) > i);
  end
  assign ladder_o = en_i ? bin_i : '0;
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int FRAME_W      = 24,
  parameter int DATA_W       = 16,
  parameter int SEG_W        = 4,
  parameter bit MIDSCALE_RST = 1'b1,
  localparam int LADDER_W    = DATA_W - SEG_W,
  localparam int THERM_W     = (1 << SEG_W) - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fs_ni,
  input  logic                sck_i,
  input  logic                sdi_i,
  output logic [DATA_W-1:0]   dac_code_o,
  output logic [1:0]          pd_mode_o,
  output logic [THERM_W-1:0]  therm_o,
  output logic [LADDER_W-1:0] ladder_o
);
  logic [2:0]         sync_w;
  logic               exec_w;
  logic [FRAME_W-1:0] word_w;
  pd_mode_e           mode_w;

  sdac_sync #(.W(3)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fs_ni, sck_i, sdi_i}),
    .q_o   (sync_w)
  );

  sdac_shift #(.FRAME_W(FRAME_W)) shift_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fs_n_i(sync_w[2]),
    .sck_i (sync_w[1]),
    .sdi_i (sync_w[0]),
    .exec_o(exec_w),
    .word_o(word_w)
  );

  sdac_regs #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .MIDSCALE_RST(MIDSCALE_RST)
  ) regs_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .exec_i(exec_w),
    .word_i(word_w),
    .code_o(dac_code_o),
    .mode_o(mode_w)
  );

  sdac_decode #(.SEG_W(SEG_W), .LADDER_W(LADDER_W)) dec_i (
    .en_i    (mode_w == PD_NORMAL),
    .seg_i   (dac_code_o[DATA_W-1 -: SEG_W]),
    .bin_i   (dac_code_o[LADDER_W-1:0]),
    .therm_o (therm_o),
    .ladder_o(ladder_o)
  );

  assign pd_mode_o = mode_w;
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
  parameter int DATA_W   = 16,
  parameter int SEG_W    = 4,
  parameter int LADDER_W = 12,
  parameter int THERM_W  = 15
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                exec_i,
  input logic [DATA_W-1:0]   dac_code_o,
  input logic [1:0]          pd_mode_o,
  input logic [THERM_W-1:0]  therm_o,
  input logic [LADDER_W-1:0] ladder_o
);
  AST_PD_SWITCHES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_mode_o != 2'b00) |-> (therm_o == '0 && ladder_o == '0)); // R12

  AST_THERM_CONTIGUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_o & (therm_o + 1'b1)) == '0)); // R7

  AST_THERM_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_mode_o == 2'b00) |->
      ($countones(therm_o) == int'(dac_code_o[DATA_W-1 -: SEG_W]))); // R7

  AST_LADDER_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_mode_o == 2'b00) |-> (ladder_o == dac_code_o[LADDER_W-1:0])); // R8

  AST_HOLD_NO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(dac_code_o) && $stable(pd_mode_o))); // R3

  AST_SINGLE_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> !exec_i); // R11
endmodule

bind sdac_frontend sdac_frontend_chk #(
  .DATA_W(DATA_W), .SEG_W(SEG_W), .LADDER_W(LADDER_W), .THERM_W(THERM_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exec_i    (exec_w),
  .dac_code_o(dac_code_o),
  .pd_mode_o (pd_mode_o),
  .therm_o   (therm_o),
  .ladder_o  (ladder_o)
);

// File: tb/sdac_frontend_tb_top.sv
module sdac_frontend_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_n = 1'b0, sck = 1'b1, sdi = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic [14:0] therm;
  logic [11:0] ladder;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fs_ni(fs_n), .sck_i(sck), .sdi_i(sdi),
    .dac_code_o(dac_code), .pd_mode_o(pd_mode), .therm_o(therm), .ladder_o(ladder)
  );

  // behavioural reference: inputs reach the frame logic two cycles late
  logic [2:0] h0 = '0, h1 = '0, h2 = '0; // {fs,sck,sdi}
  bit m_armed, m_active;
  int m_cnt;
  logic [23:0] m_acc;
  logic [15:0] m_dac;
  logic [1:0]  m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 = '0; h1 = '0; h2 = '0;
      m_armed = 0; m_active = 0; m_cnt = 0; m_acc = '0;
      m_dac = 16'h8000; m_mode = 2'b00;
    end else begin
      if (!m_active) begin
        if (h1[2]) m_armed = 1;
        else if (m_armed) begin m_active = 1; m_armed = 0; m_cnt = 0; end
      end else if (h1[2]) begin
        m_active = 0; m_armed = 1; m_cnt = 0;
      end else if (h2[1] && !h1[1]) begin
        m_acc = {m_acc[22:0], h1[0]};
        m_cnt++;
        if (m_cnt == 24) begin
          m_dac = m_acc[15:0]; m_mode = m_acc[17:16];
          m_active = 0; m_armed = 0;
        end
      end
      h2 = h1; h1 = h0; h0 = {fs_n, sck, sdi};
    end
  end

  function automatic logic [14:0] exp_therm(logic [15:0] c, logic [1:0] m);
    return (m != 2'b00) ? 15'h0 : 15'((32'd1 << c[15:12]) - 1);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dac_code !== m_dac) begin
        failures++; $display("FAIL R4 cycle dac act=%h exp=%h", dac_code, m_dac);
      end
      if (pd_mode !== m_mode) begin
        failures++; $display("FAIL R5 cycle mode act=%b exp=%b", pd_mode, m_mode);
      end
      if (therm !== exp_therm(m_dac, m_mode)) begin
        failures++; $display("FAIL R7 cycle therm act=%h exp=%h", therm, exp_therm(m_dac, m_mode));
      end
      if (ladder !== ((m_mode != 2'b00) ? 12'h0 : m_dac[11:0])) begin
        failures++; $display("FAIL R8 cycle ladder act=%h exp=%h", ladder, m_dac[11:0]);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    @(negedge clk) fs_n = 1'b1;
    @(negedge clk) fs_n = 1'b0;
    tick(4);
  endtask

  task automatic clock_bits(logic [23:0] w, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sdi = w[23-i];
      tick(3); sck = 1'b0;
      tick(4); sck = 1'b1;
    end
  endtask

  // full frame; last fall timed to check R3 latency
  task automatic frame(logic [23:0] w);
    logic [15:0] old_dac;
    rearm();
    clock_bits(w, 23);
    @(negedge clk) sdi = w[0];
    tick(3);
    old_dac = dac_code;
    sck = 1'b0;
    tick(2);
    chk("R3 no early update", 32'(dac_code), 32'(old_dac));
    tick(1);
    chk("R3 update on third edge", 32'(dac_code), 32'(w[15:0]));
    tick(4); sck = 1'b1;
    tick(4);
  endtask

  function automatic logic [14:0] th(int s);
    return 15'((32'd1 << s) - 1);
  endfunction

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R9 reset code", 32'(dac_code), 32'h8000);
    chk("R9 reset mode", 32'(pd_mode), 32'h0);
    chk("R9 reset therm", 32'(therm), 32'(th(8)));

    // R1: frame select never high since reset
    clock_bits(24'h00_1111, 24);
    tick(5);
    chk("R1 not armed", 32'(dac_code), 32'h8000);

    frame(24'hFC_1234);
    chk("R6 top bits ignored mode", 32'(pd_mode), 32'h0);
    chk("R4 code", 32'(dac_code), 32'h1234);
    chk("R7 therm seg1", 32'(therm), 32'(th(1)));
    chk("R8 ladder", 32'(ladder), 32'h234);

    // R11: extra edges with frame select still low
    clock_bits(24'hFF_FFFF, 8);
    tick(5);
    chk("R11 extra edges", 32'(dac_code), 32'h1234);

    frame(24'h00_FFFF); // rearm uses a one-cycle high pulse
    chk("R13 short rearm", 32'(dac_code), 32'hFFFF);
    chk("R7 therm full", 32'(therm), 32'(th(15)));

    frame(24'h00_8001);
    chk("R2 msb first", 32'(dac_code), 32'h8001);
    chk("R8 ladder lsb", 32'(ladder), 32'h001);

    frame(24'h01_ABCD);
    chk("R5 mode hiz", 32'(pd_mode), 32'h1);
    chk("R12 therm off", 32'(therm), 32'h0);
    chk("R12 ladder off", 32'(ladder), 32'h0);
    chk("R12 code kept", 32'(dac_code), 32'hABCD);

    frame(24'h02_5555);
    chk("R5 mode 100k", 32'(pd_mode), 32'h2);
    frame(24'hFF_7777);
    chk("R5 mode 1k", 32'(pd_mode), 32'h3);

    // R10: partial frame dropped
    rearm();
    clock_bits(24'h00_0F0F, 10);
    @(negedge clk) fs_n = 1'b1;
    tick(6);
    chk("R10 partial code", 32'(dac_code), 32'h7777);
    chk("R10 partial mode", 32'(pd_mode), 32'h3);

    frame(24'h00_0000);
    chk("R7 therm empty", 32'(therm), 32'h0);
    chk("R5 back to normal", 32'(pd_mode), 32'h0);

    tick(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule